// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the serial front end of a small sensor. It acts as an I2C target and is clocked by a fast system clock. It samples SCL and SDA lines that have already been filtered, and it pulls SDA low through an open-drain enable. It responds to one 7-bit address. The upper six bits of that address are fixed at `101011`, and the lowest bit follows a strap input, so two parts can share one bus at 56h and 57h.

Every access goes through an 8-bit register pointer.
- In a write transfer, the first byte after the address loads the pointer.
- Each later byte goes to the location the pointer names, and the pointer then advances by one.
- A read transfer starts at whatever the pointer holds. Each byte sent also advances the pointer.

The pointer advances whether or not the location is valid. An outside register bank reports whether the current location is valid and supplies its read data. Invalid locations are NACKed on write and read back as zero. Sequential access wraps from FFh to 00h. The target never stretches the clock.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, the pointer (`bank_addr`) is 00h and `sda_oe` is low.
- R2: An address byte is ACKed only when its upper seven bits equal `{6'b101011, addr_sel}`. Bit 0 of the address byte is the direction, with 1 meaning read. After a mismatching address, the target drives nothing until the next START.
- R3: In a write, the byte that follows the address loads the pointer. That byte is ACKed only if `bank_valid` is high for the new pointer value.
- R4: A data byte written to a valid location is ACKed and produces one `bank_wr` pulse. A byte written to an invalid location is NACKed and produces no write.
- R5: The pointer increments by one after every data byte, written or read, valid or not. It wraps from FFh to 00h.
- R6: Read bytes are sent MSB first. A valid location returns `bank_rdata`, and an invalid location returns 00h.
- R7: A read with no preceding pointer write starts at the current pointer value. A repeated START after the pointer byte turns the transfer into a read starting at the newly loaded pointer.
- R8: After the controller NACKs a read byte, the target releases SDA and keeps it released until the next START.
- R9: A START or STOP that arrives partway through a byte abandons that byte. No write takes place and the pointer is not stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered SCL line level |
| sda_i | input | 1 | Filtered SDA line level |
| addr_sel | input | 1 | Strap that sets address bit 0 |
| sda_oe | output | 1 | When high, SDA is pulled low |
| bank_addr | output | 8 | Current register pointer |
| bank_rd | output | 1 | One-cycle pulse when a read byte is fetched |
| bank_wr | output | 1 | One-cycle write strobe |
| bank_wdata | output | 8 | Write data for the bank |
| bank_rdata | input | 8 | Bank read data at `bank_addr` |
| bank_valid | input | 1 | High when `bank_addr` is a valid location |

## Verification
Two things happen in the same system-clock cycle: the target decides what to drive on the acknowledge bit, and it fires the write strobe. Both are taken from the same validity flag at the first SCL fall after a data byte. Page writes that cross the boundaries between valid and invalid ranges provoke this: 07h to 08h, the isolated valid location 0Bh, and the wrap from FFh to 00h. The bench judges the result by comparing every ACK bit against its own validity model, and by checking that the count of bank writes matches the number of valid bytes. A second overlap, between abort detection and the byte in flight, is provoked by issuing a STOP or START after only a few bits of a byte, and is judged by the write count and by reading back from the unchanged pointer.

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
  parameter logic [5:0] ADDR_HI = 6'b101011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_oe,
  output logic [7:0] bank_addr,
  output logic       bank_rd,
  output logic       bank_wr,
  output logic [7:0] bank_wdata,
  input  logic [7:0] bank_rdata,
  input  logic       bank_valid
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_RNXT
  } st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [7:0] sr, ptr;
  logic [3:0] cnt;
  logic       rw, ack_on;

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire [7:0] rx      = {sr[6:0], sda_p[1]};
  wire [7:0] rd_byte = bank_valid ? bank_rdata : 8'h00;
  wire       ack_val = (st == ST_AACK) | bank_valid;

  assign bank_addr  = ptr;
  assign bank_wdata = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p   <= 3'b111;
      sda_p   <= 3'b111;
      st      <= ST_IDLE;
      sr      <= 8'h00;
      ptr     <= 8'h00;
      cnt     <= 4'd0;
      rw      <= 1'b0;
      ack_on  <= 1'b0;
      sda_oe  <= 1'b0;
      bank_rd <= 1'b0;
      bank_wr <= 1'b0;
    end else begin
      scl_p   <= {scl_p[1:0], scl_i};
      sda_p   <= {sda_p[1:0], sda_i};
      bank_rd <= 1'b0;
      bank_wr <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        cnt    <= 4'd0;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WDAT:
            if (scl_rise) begin
              sr  <= rx;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (st == ST_ADDR) begin
                  if (rx[7:1] == {ADDR_HI, addr_sel}) begin
                    rw <= rx[0];
                    st <= ST_AACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end else if (st == ST_PTR) begin
                  ptr <= rx;
                  st  <= ST_PACK;
                end else begin
                  st <= ST_WACK;
                end
              end
            end
          ST_AACK, ST_PACK, ST_WACK:
            if (scl_fall) begin
              if (!ack_on) begin
                ack_on  <= 1'b1;
                sda_oe  <= ack_val;
                bank_wr <= (st == ST_WACK) && bank_valid;
              end else begin
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
                cnt    <= 4'd0;
                if (st == ST_AACK && rw) begin
                  sr      <= rd_byte;
                  sda_oe  <= ~rd_byte[7];
                  bank_rd <= 1'b1;
                  st      <= ST_RDAT;
                end else if (st == ST_AACK) begin
                  st <= ST_PTR;
                end else begin
                  st <= ST_WDAT;
                  if (st == ST_WACK) ptr <= ptr + 8'd1;
                end
              end
            end
          ST_RDAT: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else if (cnt != 4'd0) begin
                sda_oe <= ~sr[6];
                sr     <= {sr[6:0], 1'b0};
              end
            end
          end
          ST_RACK:
            if (scl_rise) begin
              ptr <= ptr + 8'd1;
              st  <= sda_p[1] ? ST_IDLE : ST_RNXT;
            end
          ST_RNXT:
            if (scl_fall) begin
              sr      <= rd_byte;
              sda_oe  <= ~rd_byte[7];
              bank_rd <= 1'b1;
              cnt     <= 4'd0;
              st      <= ST_RDAT;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_ptr_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [7:0] bank_addr,
  input logic       bank_rd,
  input logic       bank_wr,
  input logic       bank_valid
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (bank_addr == 8'h00 && !sda_oe));

  assert_wr_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> bank_valid);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> !bank_wr);

  assert_ptr_hold_on_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> $stable(bank_addr));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd |=> !bank_rd);

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_rd && bank_wr));
endmodule

bind i2c_ptr_target i2c_ptr_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .bank_addr(bank_addr),
  .bank_rd(bank_rd), .bank_wr(bank_wr), .bank_valid(bank_valid)
);

// File: tb/tb_i2c_ptr_target.sv
module tb_i2c_ptr_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, bank_rd, bank_wr, bank_valid;
  logic [7:0] bank_addr, bank_wdata, bank_rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] bank_mem [256];
  logic [7:0] model_mem [256];
  logic [7:0] mptr;
  int total = 0, fails = 0, wr_cnt = 0, bad_wr = 0, exp_wr = 0;

  function automatic logic vld(input logic [7:0] a);
    return (a < 8'h08) || (a == 8'h0B);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    return vld(a) ? model_mem[a] : 8'h00;
  endfunction

  assign bank_valid = vld(bank_addr);
  assign bank_rdata = bank_mem[bank_addr];

  always_ff @(posedge clk) begin
    if (bank_wr) begin
      bank_mem[bank_addr] <= bank_wdata;
      wr_cnt <= wr_cnt + 1;
      if (!vld(bank_addr)) bad_wr <= bad_wr + 1;
    end
  end

  i2c_ptr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .bank_addr(bank_addr), .bank_rd(bank_rd), .bank_wr(bank_wr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .bank_valid(bank_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wq(1); scl = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wq(1); scl = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; wq(1); scl = 1'b1; wq(1); s = sda_line; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    bit_io(~mack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic rd);
    return {6'b101011, addr_sel, rd};
  endfunction

  task automatic write_body(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] d;
    send_byte(addr_byte(1'b0), a);
    check(a == 1'b1, "R2 write address ack", a, 1);
    send_byte(p, a);
    check(a == vld(p), "R3 pointer byte ack", a, vld(p));
    mptr = p;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, a);
      check(a == vld(mptr), "R4 data ack", a, vld(mptr));
      if (vld(mptr)) begin
        model_mem[mptr] = d;
        exp_wr++;
      end
      mptr = mptr + 8'd1;
    end
  endtask

  task automatic read_body(input int n, input string tag);
    logic a;
    logic [7:0] d;
    send_byte(addr_byte(1'b1), a);
    check(a == 1'b1, "R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(d == exp_rd(mptr), tag, d, exp_rd(mptr));
      mptr = mptr + 8'd1;
    end
    wq(1);
    check(sda_oe == 1'b0, "R8 release after NACK", sda_oe, 0);
  endtask

  task automatic do_write(input logic [7:0] p, input int n);
    i2c_start; write_body(p, n); i2c_stop;
    check(wr_cnt == exp_wr && bad_wr == 0, "R4 write count", wr_cnt, exp_wr);
  endtask

  task automatic do_read(input int n);
    i2c_start; read_body(n, "R7 read from current pointer"); i2c_stop;
  endtask

  task automatic do_ptr_read(input logic [7:0] p, input int n);
    i2c_start; write_body(p, 0); i2c_start; read_body(n, "R6 R7 repeated start read"); i2c_stop;
  endtask

  initial begin
    logic a, s;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 256; i++) begin
      bank_mem[i] = 8'($urandom) | 8'h01;
      model_mem[i] = bank_mem[i];
    end
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    check(bank_addr == 8'h00, "R1 pointer reset", bank_addr, 0);
    check(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
    rst_n = 1'b1;
    wq(2);

    do_read(3);

    i2c_start;
    send_byte({7'h58, 1'b0}, a);
    check(a == 1'b0, "R2 foreign address NACK", a, 0);
    send_byte(8'h00, a);
    check(a == 1'b0, "R2 silent after mismatch", a, 0);
    i2c_stop;
    addr_sel = 1'b1;
    i2c_start;
    send_byte({7'h56, 1'b1}, a);
    check(a == 1'b0, "R2 strap high rejects 56h", a, 0);
    i2c_stop;
    do_read(2);
    addr_sel = 1'b0;

    do_write(8'h06, 7);
    do_ptr_read(8'h05, 8);
    do_write(8'hFF, 3);
    do_ptr_read(8'hFE, 5);
    check(mptr == 8'h03, "R5 pointer wrapped", mptr, 3);

    i2c_start;
    write_body(8'h02, 0);
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    i2c_stop;
    check(wr_cnt == exp_wr, "R9 STOP abort no write", wr_cnt, exp_wr);
    do_read(2);
    i2c_start;
    write_body(8'h04, 0);
    for (int i = 0; i < 5; i++) bit_io(1'b1, s);
    i2c_start;
    read_body(2, "R9 START abort then read");
    i2c_stop;
    check(wr_cnt == exp_wr, "R9 START abort no write", wr_cnt, exp_wr);

    for (int it = 0; it < 25; it++) begin
      logic [7:0] p;
      int n, k;
      p = ($urandom % 2) ? 8'($urandom % 16) : (8'hF8 | 8'($urandom % 8));
      n = 1 + int'($urandom % 5);
      k = int'($urandom % 3);
      addr_sel = 1'($urandom);
      if (k == 0) do_write(p, n);
      else if (k == 1) do_ptr_read(p, n);
      else do_read(n);
    end
    check(bad_wr == 0, "R4 no write to invalid location", bad_wr, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule